// File: doc/BRIEF.md
# Floating-Point Context Save/Restore Sequencer

This block carries out a two-instruction group that moves the whole floating-point register context to memory or back. It takes a decoded instruction from the pipeline: two opcode bytes, the ModR/M byte and an effective address that has already been computed. It also takes the operating-system enable bit and a one-cycle start strobe. It checks the instruction for faults, then runs a fixed sequence of 16-byte memory beats. A save beat carries data out of the register file, and a restore beat carries memory data back in.

The memory image is 160 bytes, split into ten 16-byte beats in ascending address order. The first two beats hold a 256-bit control header: control, status and tag words plus the last-instruction and last-operand pointers. Beats 2 to 9 each hold one 80-bit stack register, register 0 first. The 80-bit value sits in the low bits of its beat. A restore collects every beat in a staging buffer and writes the register file only once all ten beats have come back clean.

Top module: `fpctx_seq`

## Requirements
- R1: The group is recognised when the first opcode byte is 0x0F and the second is 0xAE. The ModR/M reg field (bits 5:3) set to 000 selects save (memory writes, `mem_we`=1). Set to 001 it selects restore (memory reads, `mem_we`=0).
- R2: If `os_en` is 0, a recognised group instruction raises `fault_valid` with `fault_vec`=6 and makes no memory request. This check wins over every other fault.
- R3: With `os_en`=1, a ModR/M mod field (bits 7:6) of 11 raises `fault_valid` with `fault_vec`=6 and makes no memory request. This check wins over misalignment.
- R4: With `os_en`=1 and a memory form, an address whose bits 3:0 are not all zero raises `fault_valid` with `fault_vec`=13 and makes no memory request.
- R5: `fault_valid`, `not_handled` and `done` are one-cycle pulses that are never high together. A fault or not-handled pulse appears in the cycle after the accepted strobe, and each strobe yields at most one fault vector. `fault_vec` reads 0 whenever `fault_valid` is low.
- R6: Any other opcode pair, or a reg field other than 000 or 001 within the group, pulses `not_handled`. It raises no fault and makes no memory request.
- R7: A save issues 10 beats at addresses ea, ea+16, ... ea+144. Beats 0 and 1 carry header bits 127:0 and 255:128. Beat 2+k carries stack register k in bits 79:0, with bits 127:80 driven as zero.
- R8: A restore reads the same 10 addresses. After the last clean response, `rf_we` pulses once. `rf_hdr_wr` then holds beats 0 and 1, and register k of `rf_st_wr` holds bits 79:0 of beat 2+k. Bits 127:80 of each register beat have no effect.
- R9: `busy` and `mem_req` rise in the cycle after an accepted strobe. They hold the current address stable until a response arrives, and they fall in the cycle after the tenth response, when `done` pulses for exactly one cycle.
- R10: A response with `mem_rsp_err`=1 ends the sequence. No further request is made, `done` pulses with `xfer_err`=1, and `rf_we` does not pulse.
- R11: A start strobe while `busy` is high has no effect, and a response while `mem_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe: instruction fields are valid |
| op_esc | input | 8 | First opcode byte |
| op_grp | input | 8 | Second opcode byte |
| modrm | input | 8 | ModR/M byte |
| ea | input | 32 | Effective address of the image |
| os_en | input | 1 | Operating-system enable for the group |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| xfer_err | output | 1 | With `done`: sequence aborted by an error response |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_vec | output | 8 | Fault vector number (6 or 13) |
| not_handled | output | 1 | One-cycle pulse: instruction not in this group |
| mem_req | output | 1 | Beat request, held until a response arrives |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 128 | Write beat data |
| mem_rsp_valid | input | 1 | Response for the current beat |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rdata | input | 128 | Read beat data |
| rf_hdr_rd | input | 256 | Current control header |
| rf_st_rd | input | 640 | Current stack registers, register k at bits 80k+79:80k |
| rf_we | output | 1 | One-cycle register file write strobe |
| rf_hdr_wr | output | 256 | Header value to write |
| rf_st_wr | output | 640 | Stack register values to write |

## Verification
Saves run at memory latencies of one and three cycles per beat. This separates a design that holds each request until its response from one that moves on by a fixed cycle count. Restores read images whose padding bytes are random. This shows that the padding is dropped, and a save followed by a restore shows that the two layouts match. Fault cases cover each single fault and each pair of faults together, so the checks reveal the priority order rather than just the vector values. An error on the sixth beat, a start strobe in the middle of a save, and a stray response while idle show that aborts and unexpected inputs leave the state and outputs as expected.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;
  localparam logic [7:0] ESC_BYTE = 8'h0F;
  localparam logic [7:0] GRP_BYTE = 8'hAE;
  localparam logic [2:0] SEL_SAVE = 3'b000;
  localparam logic [2:0] SEL_LOAD = 3'b001;
  localparam logic [1:0] MOD_REG  = 2'b11;
  localparam logic [7:0] VEC_UD   = 8'd6;
  localparam logic [7:0] VEC_GP   = 8'd13;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_FAULT = 2'd1,
    DEC_SAVE  = 2'd2,
    DEC_LOAD  = 2'd3
  } dec_kind_e;

  typedef struct packed {
    dec_kind_e  kind;
    logic [7:0] vec;
  } dec_res_t;
endpackage

// File: rtl/fpctx_decode.sv
module fpctx_decode
  import fpctx_pkg::*;
#(
  parameter int ALIGN_BITS = 4
) (
  input  logic [7:0]            op_esc,
  input  logic [7:0]            op_grp,
  input  logic [1:0]            mod_fld,
  input  logic [2:0]            reg_fld,
  input  logic [ALIGN_BITS-1:0] ea_lo,
  input  logic                  os_en,
  output dec_res_t              res
);
  logic in_group;

  assign in_group = (op_esc == ESC_BYTE) && (op_grp == GRP_BYTE) &&
                    ((reg_fld == SEL_SAVE) || (reg_fld == SEL_LOAD));

  // fixed priority: disabled, register form, misaligned
  always_comb begin
    res.kind = DEC_NONE;
    res.vec  = '0;
    if (in_group) begin
      if (!os_en) begin
        res.kind = DEC_FAULT;
        res.vec  = VEC_UD;
      end else if (mod_fld == MOD_REG) begin
        res.kind = DEC_FAULT;
        res.vec  = VEC_UD;
      end else if (|ea_lo) begin
        res.kind = DEC_FAULT;
        res.vec  = VEC_GP;
      end else if (reg_fld == SEL_SAVE) begin
        res.kind = DEC_SAVE;
      end else begin
        res.kind = DEC_LOAD;
      end
    end
  end
endmodule

// File: rtl/fpctx_stage.sv
module fpctx_stage #(
  parameter int BEAT_W    = 128,
  parameter int REG_W     = 80,
  parameter int NREG      = 8,
  parameter int HDR_BEATS = 2,
  localparam int NBEATS   = HDR_BEATS + NREG,
  localparam int BIDX_W   = $clog2(NBEATS),
  localparam int HDR_W    = HDR_BEATS * BEAT_W,
  localparam int ST_W     = NREG * REG_W,
  localparam int PAD_W    = BEAT_W - REG_W
) (
  input  logic              clk,
  input  logic              cap_en,
  input  logic [BIDX_W-1:0] cap_idx,
  input  logic [BEAT_W-1:0] cap_data,
  input  logic [BIDX_W-1:0] sel_idx,
  input  logic [HDR_W-1:0]  hdr_rd,
  input  logic [ST_W-1:0]   st_rd,
  output logic [BEAT_W-1:0] save_word,
  output logic [HDR_W-1:0]  hdr_wr,
  output logic [ST_W-1:0]   st_wr
);
  logic [BEAT_W-1:0] stage_q [NBEATS];
  logic [BEAT_W-1:0] words   [NBEATS];
  logic [NREG-1:0]   unused_pad;

  // staging store: one beat written per cycle, no reset
  always_ff @(posedge clk) begin
    if (cap_en) stage_q[cap_idx] <= cap_data;
  end

  for (genvar h = 0; h < HDR_BEATS; h++) begin : g_hdr
    assign words[h] = hdr_rd[h*BEAT_W +: BEAT_W];
    assign hdr_wr[h*BEAT_W +: BEAT_W] = stage_q[h];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign words[HDR_BEATS+r] = {{PAD_W{1'b0}}, st_rd[r*REG_W +: REG_W]};
    assign st_wr[r*REG_W +: REG_W] = stage_q[HDR_BEATS+r][REG_W-1:0];
    assign unused_pad[r] = ^stage_q[HDR_BEATS+r][BEAT_W-1:REG_W];
  end

  assign save_word = (sel_idx < BIDX_W'(NBEATS)) ? words[sel_idx] : '0;
endmodule

// File: rtl/fpctx_beat_ctrl.sv
module fpctx_beat_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int NBEATS     = 10,
  parameter int BEAT_BYTES = 16,
  localparam int BIDX_W    = $clog2(NBEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_save,
  input  logic              launch_load,
  input  logic [ADDR_W-1:0] ea,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [BIDX_W-1:0] beat,
  output logic              wd_load,
  output logic [BIDX_W-1:0] wd_idx,
  output logic              cap_en,
  output logic              done,
  output logic              xfer_err,
  output logic              commit
);
  logic              busy_q, we_q, done_q, err_q, commit_q;
  logic [BIDX_W-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last, launch, adv;

  assign last   = (beat_q == BIDX_W'(NBEATS - 1));
  assign launch = !busy_q && (launch_save || launch_load);
  assign adv    = busy_q && rsp_valid && !rsp_err && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      we_q     <= 1'b0;
      beat_q   <= '0;
      addr_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      commit_q <= 1'b0;
      if (launch) begin
        busy_q <= 1'b1;
        we_q   <= launch_save;
        beat_q <= '0;
        addr_q <= ea;
      end else if (busy_q && rsp_valid) begin
        if (rsp_err || last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          err_q    <= rsp_err;
          commit_q <= !we_q && !rsp_err;
        end else begin
          beat_q <= beat_q + BIDX_W'(1);
          addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
        end
      end
    end
  end

  assign busy     = busy_q;
  assign we       = we_q;
  assign addr     = addr_q;
  assign beat     = beat_q;
  assign wd_load  = launch || adv;
  assign wd_idx   = launch ? '0 : beat_q + BIDX_W'(1);
  assign cap_en   = busy_q && rsp_valid && !rsp_err && !we_q;
  assign done     = done_q;
  assign xfer_err = err_q;
  assign commit   = commit_q;

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !rsp_valid |=> busy_q && $stable(addr_q));

  // R10
  commit_clean_chk: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> done_q && !err_q && !we_q);

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && rsp_valid && rsp_err |=> !busy_q && !commit_q);
endmodule

// File: rtl/fpctx_seq.sv
module fpctx_seq
  import fpctx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BEAT_W    = 128,
  parameter int REG_W     = 80,
  parameter int NREG      = 8,
  parameter int HDR_BEATS = 2,
  localparam int NBEATS     = HDR_BEATS + NREG,
  localparam int BEAT_BYTES = BEAT_W / 8,
  localparam int ALIGN_BITS = $clog2(BEAT_BYTES),
  localparam int BIDX_W     = $clog2(NBEATS),
  localparam int HDR_W      = HDR_BEATS * BEAT_W,
  localparam int ST_W       = NREG * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        op_esc,
  input  logic [7:0]        op_grp,
  input  logic [7:0]        modrm,
  input  logic [ADDR_W-1:0] ea,
  input  logic              os_en,
  output logic              busy,
  output logic              done,
  output logic              xfer_err,
  output logic              fault_valid,
  output logic [7:0]        fault_vec,
  output logic              not_handled,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BEAT_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [BEAT_W-1:0] mem_rdata,
  input  logic [HDR_W-1:0]  rf_hdr_rd,
  input  logic [ST_W-1:0]   rf_st_rd,
  output logic              rf_we,
  output logic [HDR_W-1:0]  rf_hdr_wr,
  output logic [ST_W-1:0]   rf_st_wr
);
  dec_res_t          dec;
  logic              accept;
  logic              launch_save, launch_load;
  logic              fault_q, nh_q;
  logic [7:0]        vec_q;
  logic [BEAT_W-1:0] wdata_q;
  logic [BEAT_W-1:0] save_word;
  logic              wd_load, cap_en;
  logic [BIDX_W-1:0] wd_idx, beat;
  logic              unused_rm;

  assign unused_rm = ^modrm[2:0];

  fpctx_decode #(.ALIGN_BITS(ALIGN_BITS)) u_decode (
    .op_esc  (op_esc),
    .op_grp  (op_grp),
    .mod_fld (modrm[7:6]),
    .reg_fld (modrm[5:3]),
    .ea_lo   (ea[ALIGN_BITS-1:0]),
    .os_en   (os_en),
    .res     (dec)
  );

  assign accept      = start && !busy;
  assign launch_save = accept && (dec.kind == DEC_SAVE);
  assign launch_load = accept && (dec.kind == DEC_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      vec_q   <= '0;
      nh_q    <= 1'b0;
    end else begin
      fault_q <= accept && (dec.kind == DEC_FAULT);
      vec_q   <= (accept && (dec.kind == DEC_FAULT)) ? dec.vec : '0;
      nh_q    <= accept && (dec.kind == DEC_NONE);
    end
  end

  fpctx_beat_ctrl #(
    .ADDR_W     (ADDR_W),
    .NBEATS     (NBEATS),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .launch_save (launch_save),
    .launch_load (launch_load),
    .ea          (ea),
    .rsp_valid   (mem_rsp_valid),
    .rsp_err     (mem_rsp_err),
    .busy        (busy),
    .we          (mem_we),
    .addr        (mem_addr),
    .beat        (beat),
    .wd_load     (wd_load),
    .wd_idx      (wd_idx),
    .cap_en      (cap_en),
    .done        (done),
    .xfer_err    (xfer_err),
    .commit      (rf_we)
  );

  fpctx_stage #(
    .BEAT_W    (BEAT_W),
    .REG_W     (REG_W),
    .NREG      (NREG),
    .HDR_BEATS (HDR_BEATS)
  ) u_stage (
    .clk       (clk),
    .cap_en    (cap_en),
    .cap_idx   (beat),
    .cap_data  (mem_rdata),
    .sel_idx   (wd_idx),
    .hdr_rd    (rf_hdr_rd),
    .st_rd     (rf_st_rd),
    .save_word (save_word),
    .hdr_wr    (rf_hdr_wr),
    .st_wr     (rf_st_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) wdata_q <= '0;
    else if (wd_load) wdata_q <= save_word;
  end

  assign mem_req     = busy;
  assign mem_wdata   = wdata_q;
  assign fault_valid = fault_q;
  assign fault_vec   = vec_q;
  assign not_handled = nh_q;

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_q, nh_q, done}));

  // R2 R3 R4
  fault_noacc_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> ((vec_q == VEC_UD) || (vec_q == VEC_GP)) && !busy);

  // R4
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start && !mem_rsp_valid |=> busy && !fault_q && !nh_q);
endmodule

// File: tb/fpctx_seq_bench.sv
`timescale 1ns/1ps
module fpctx_seq_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [7:0]   op_esc = 8'h00, op_grp = 8'h00, modrm = 8'h00;
  logic [31:0]  ea = 32'h0;
  logic         os_en = 1'b1;
  logic         busy, done, xfer_err, fault_valid, not_handled;
  logic [7:0]   fault_vec;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_rsp_valid;
  logic         r_valid = 1'b0, inj_v = 1'b0;
  logic         r_err = 1'b0, inj_err = 1'b0;
  logic         mem_rsp_err;
  logic [127:0] mem_rdata = '0;
  logic [255:0] hdr_src;
  logic [639:0] st_src;
  logic         rf_we;
  logic [255:0] rf_hdr_wr;
  logic [639:0] rf_st_wr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  assign mem_rsp_valid = r_valid | inj_v;
  assign mem_rsp_err   = r_valid ? r_err : inj_err;

  fpctx_seq u_fpctx_seq (
    .clk(clk), .rst(rst), .start(start), .op_esc(op_esc), .op_grp(op_grp),
    .modrm(modrm), .ea(ea), .os_en(os_en), .busy(busy), .done(done),
    .xfer_err(xfer_err), .fault_valid(fault_valid), .fault_vec(fault_vec),
    .not_handled(not_handled), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata), .rf_hdr_rd(hdr_src),
    .rf_st_rd(st_src), .rf_we(rf_we), .rf_hdr_wr(rf_hdr_wr), .rf_st_wr(rf_st_wr)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory model
  bit [127:0] mem [int unsigned];
  int  lat = 0;
  int  r_wait = 0;
  bit  err_en = 0;
  logic [31:0] err_addr = '0;

  function automatic logic [127:0] rd_mem(input int unsigned key);
    if (mem.exists(key)) return mem[key];
    return '0;
  endfunction

  always @(negedge clk) begin
    if (rst || !mem_req) begin
      r_valid = 1'b0; r_wait = 0;
    end else if (r_valid) begin
      r_valid = 1'b0; r_wait = 0;
    end else if (r_wait >= lat) begin
      if (err_en && mem_addr == err_addr) begin
        r_err = 1'b1;
      end else begin
        r_err = 1'b0;
        if (mem_we) mem[mem_addr >> 4] = mem_wdata;
        else mem_rdata = rd_mem(mem_addr >> 4);
      end
      r_valid = 1'b1;
    end else begin
      r_wait++;
    end
  end

  // behavioural reference model
  bit m_busy = 0, m_save = 0, m_done = 0, m_err = 0, m_fault = 0, m_nh = 0, m_rfwe = 0;
  int m_beat = 0;
  logic [7:0]  m_vec = '0;
  logic [31:0] m_ea = '0;
  int rfwe_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_fault = 0; m_nh = 0; m_rfwe = 0;
      m_vec = '0; m_beat = 0;
    end else begin
      m_done = 0; m_err = 0; m_fault = 0; m_nh = 0; m_rfwe = 0; m_vec = '0;
      if (!m_busy) begin
        if (start) begin
          if (!(op_esc == 8'h0F && op_grp == 8'hAE &&
                (modrm[5:3] == 3'd0 || modrm[5:3] == 3'd1))) m_nh = 1;
          else if (!os_en) begin m_fault = 1; m_vec = 8'd6; end
          else if (modrm[7:6] == 2'b11) begin m_fault = 1; m_vec = 8'd6; end
          else if (ea[3:0] != 4'h0) begin m_fault = 1; m_vec = 8'd13; end
          else begin
            m_busy = 1; m_save = (modrm[5:3] == 3'd0); m_ea = ea; m_beat = 0;
          end
        end
      end else if (mem_rsp_valid) begin
        if (mem_rsp_err || m_beat == 9) begin
          m_busy = 0; m_done = 1; m_err = mem_rsp_err;
          m_rfwe = !m_save && !mem_rsp_err;
        end else begin
          m_beat++;
        end
      end
    end
  end

  function automatic logic [127:0] img_word(input int k);
    if (k < 2) return hdr_src[k*128 +: 128];
    return {48'h0, st_src[(k-2)*80 +: 80]};
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      chk("R9 busy", 128'(busy), 128'(m_busy));
      chk("R9 done", 128'(done), 128'(m_done));
      chk("R10 xfer_err", 128'(xfer_err), 128'(m_err));
      chk("R5 fault_valid", 128'(fault_valid), 128'(m_fault));
      chk("R2 fault_vec", 128'(fault_vec), 128'(m_vec));
      chk("R6 not_handled", 128'(not_handled), 128'(m_nh));
      chk("R9 mem_req", 128'(mem_req), 128'(m_busy));
      chk("R8 rf_we", 128'(rf_we), 128'(m_rfwe));
      if (m_busy) begin
        chk("R7 mem_addr", 128'(mem_addr), 128'(m_ea + 32'(16 * m_beat)));
        chk("R1 mem_we", 128'(mem_we), 128'(m_save));
        if (m_save) chk("R7 mem_wdata", mem_wdata, img_word(m_beat));
      end
      if (rf_we) rfwe_cnt++;
      if (m_rfwe) begin
        for (int k = 0; k < 2; k++)
          chk("R8 header", rf_hdr_wr[k*128 +: 128], rd_mem((m_ea >> 4) + k));
        for (int r = 0; r < 8; r++)
          chk("R8 stack reg", {48'h0, rf_st_wr[r*80 +: 80]},
              {48'h0, rd_mem((m_ea >> 4) + 2 + r)[79:0]});
      end
    end
  end

  task automatic issue(input logic [7:0] e, input logic [7:0] g, input logic [7:0] m,
                       input logic [31:0] a, input logic os);
    @(negedge clk);
    op_esc = e; op_grp = g; modrm = m; ea = a; os_en = os; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fault_case(input string tag, input logic [7:0] m, input logic [31:0] a,
                            input logic os, input logic [7:0] vec);
    issue(8'h0F, 8'hAE, m, a, os);
    chk(tag, {fault_valid, fault_vec, mem_req}, {1'b1, vec, 1'b0});
    settle();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt0;
    hdr_src = {64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444,
               64'hFEDC_BA98_7654_3210, 64'h037F_0000_FFFF_0000};
    for (int r = 0; r < 8; r++)
      st_src[r*80 +: 80] = {16'(16'h3FF0 + r), 32'hC0DE_0000 | 32'(r), 32'hA5A5_5A5A ^ 32'(r * 7)};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset busy", 128'(busy), 128'h0);
    chk("R5 reset pulses", 128'({done, fault_valid, not_handled, rf_we}), 128'h0);

    // R1 R7: save, fast memory then slow memory
    lat = 0;
    issue(8'h0F, 8'hAE, 8'h06, 32'h0000_1000, 1'b1);
    settle();
    for (int k = 0; k < 10; k++) chk("R7 save image", rd_mem(32'h100 + k), img_word(k));
    lat = 2;
    issue(8'h0F, 8'hAE, 8'h47, 32'h0000_2000, 1'b1);
    settle();
    for (int k = 0; k < 10; k++) chk("R7 save image slow", rd_mem(32'h200 + k), img_word(k));

    // R8: restore from image with random padding
    lat = 1;
    for (int k = 0; k < 10; k++)
      mem[32'h300 + k] = {$urandom, $urandom, $urandom, $urandom};
    cnt0 = rfwe_cnt;
    issue(8'h0F, 8'hAE, 8'h4F, 32'h0000_3000, 1'b1);
    settle();
    chk("R8 one write strobe", 128'(rfwe_cnt - cnt0), 128'd1);

    // R8: round trip of the saved image
    issue(8'h0F, 8'hAE, 8'h0E, 32'h0000_1000, 1'b1);
    settle();
    chk("R8 roundtrip hdr lo", rf_hdr_wr[127:0], hdr_src[127:0]);
    chk("R8 roundtrip hdr hi", rf_hdr_wr[255:128], hdr_src[255:128]);
    for (int r = 0; r < 8; r++)
      chk("R8 roundtrip reg", {48'h0, rf_st_wr[r*80 +: 80]}, {48'h0, st_src[r*80 +: 80]});

    // R2 R3 R4: faults and their priority
    fault_case("R2 disabled", 8'h06, 32'h0000_4000, 1'b0, 8'd6);
    fault_case("R2 disabled over all", 8'hC8, 32'h0000_4004, 1'b0, 8'd6);
    fault_case("R3 register form", 8'hC0, 32'h0000_4000, 1'b1, 8'd6);
    fault_case("R3 register form over misalign", 8'hC8, 32'h0000_4008, 1'b1, 8'd6);
    fault_case("R4 misaligned", 8'h06, 32'h0000_4001, 1'b1, 8'd13);
    fault_case("R4 misaligned restore", 8'h4F, 32'h0000_400C, 1'b1, 8'd13);

    // R6: not handled
    issue(8'h0F, 8'hAE, 8'h16, 32'h0000_5000, 1'b1);
    chk("R6 reg field 010", {fault_valid, not_handled, mem_req}, 3'b010);
    settle();
    issue(8'h0F, 8'hAF, 8'h06, 32'h0000_5000, 1'b0);
    chk("R6 other opcode", {fault_valid, not_handled, mem_req}, 3'b010);
    settle();

    // R10: error on the sixth beat of a restore
    lat = 0;
    err_en = 1; err_addr = 32'h0000_3050;
    cnt0 = rfwe_cnt;
    issue(8'h0F, 8'hAE, 8'h4F, 32'h0000_3000, 1'b1);
    settle();
    chk("R10 no write after abort", 128'(rfwe_cnt - cnt0), 128'd0);
    chk("R10 no request after abort", 128'(mem_req), 128'h0);
    err_en = 0;

    // R11: start while busy, and stray response while idle
    lat = 1;
    issue(8'h0F, 8'hAE, 8'h06, 32'h0000_6000, 1'b1);
    repeat (3) @(negedge clk);
    op_esc = 8'h0F; op_grp = 8'hAE; modrm = 8'hC0; ea = 32'h0000_7003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 start while busy", {busy, fault_valid, not_handled}, 3'b100);
    settle();
    for (int k = 0; k < 10; k++) chk("R11 image intact", rd_mem(32'h600 + k), img_word(k));
    inj_v = 1'b1; inj_err = 1'b0;
    @(negedge clk);
    inj_v = 1'b0;
    chk("R11 stray response", {busy, done, rf_we}, 3'b000);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule